// File: doc/BRIEF.md
# Cascadable Dual Byte Timer

This block holds two free-running up-counters, each one byte wide by default. A mode input decides how they relate. With the mode input low, they are two unrelated 8-bit timers, and each one has its own run input. With the mode input high, they form one 16-bit timer. The first counter is the low byte, and its wrap from all ones to zero carries into the second counter, which is the high byte.

In the joined mode, the low counter's run input starts and stops the whole pair. The high byte still needs its own run input set before a carry can advance it. If that input is clear, the low byte keeps running and wraps, and the upper byte stays where it is.

Software loads either counter through a single write port. The counter values are always visible on the outputs, so they can be read back there. Registered one-cycle pulses report a wrap of the low counter, a wrap of the high counter and, in the joined mode, a wrap of the full pair.

Top module: `dual_tick_counter`

## Requirements
- R1: After reset both counters read 0 and all three wrap pulses are 0; both timers stay stopped until a run input is raised.
- R2: The low counter increments by one on each clock edge at which `run_lo` is 1 and holds otherwise, in both modes.
- R3: With `pair_mode` = 0, the high counter increments by one on each clock edge at which `run_hi` is 1 and holds otherwise, whatever the low counter does.
- R4: With `pair_mode` = 1, the high counter increments only on the edge at which the low counter steps from all ones to 0, and only while both `run_lo` and `run_hi` are 1.
- R5: With `pair_mode` = 1 and `run_lo` = 0, both counters hold, even if `run_hi` is 1.
- R6: With `pair_mode` = 1, `run_lo` = 1 and `run_hi` = 0, the low counter keeps counting and wraps, but the high counter holds.
- R7: A write (`wr_en` = 1) loads `wr_data` into the low counter when `wr_sel` = 0 and into the high counter when `wr_sel` = 1 at the next edge, and this overrides any increment of that counter. A write to the low counter in the joined mode also cancels the carry for that edge.
- R8: `wrap_lo` is 1 for exactly the one cycle after the low counter steps from all ones to 0 by counting.
- R9: `wrap_hi` is 1 for exactly the one cycle after the high counter steps from all ones to 0 by counting.
- R10: `wrap_pair` is 1 for one cycle only when, in the joined mode, both bytes step to 0 on the same edge. It is never 1 with `pair_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_mode | input | 1 | 1 joins the counters into one 16-bit timer |
| run_lo | input | 1 | Run input of the low counter (of the pair when joined) |
| run_hi | input | 1 | Run input of the high counter |
| wr_en | input | 1 | Load strobe |
| wr_sel | input | 1 | Load target: 0 low, 1 high |
| wr_data | input | WIDTH | Load value |
| count_lo | output | WIDTH | Low counter value |
| count_hi | output | WIDTH | High counter value |
| wrap_lo | output | 1 | Low counter wrap pulse |
| wrap_hi | output | 1 | High counter wrap pulse |
| wrap_pair | output | 1 | Joined pair wrap pulse |

## Verification
The assertions assume that every input is a known 0 or 1 at each clock edge. They also assume that `pair_mode` changes only between edges, so that the value present at an edge is the one that applies to that edge's step. The bench drives all inputs on the falling edge and holds them through the next rising edge. It changes the mode only while both run inputs are low, and it places the counters next to each wrap point through the load port, so it never relies on long runs to reach them.

// File: rtl/dual_tick_counter.sv
module dual_tick_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_mode,
  input  logic             run_lo,
  input  logic             run_hi,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] count_lo,
  output logic [WIDTH-1:0] count_hi,
  output logic             wrap_lo,
  output logic             wrap_hi,
  output logic             wrap_pair
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic load_lo, load_hi;
  logic step_lo, step_hi;
  logic carry, hi_rolls;

  assign load_lo  = wr_en & ~wr_sel;
  assign load_hi  = wr_en & wr_sel;
  assign step_lo  = run_lo & ~load_lo;
  assign carry    = step_lo & (count_lo == ALL_ONES);
  assign step_hi  = ~load_hi & (pair_mode ? (carry & run_hi) : run_hi);
  assign hi_rolls = step_hi & (count_hi == ALL_ONES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_lo  <= '0;
      count_hi  <= '0;
      wrap_lo   <= 1'b0;
      wrap_hi   <= 1'b0;
      wrap_pair <= 1'b0;
    end else begin
      count_lo  <= load_lo ? wr_data : count_lo + WIDTH'(step_lo);
      count_hi  <= load_hi ? wr_data : count_hi + WIDTH'(step_hi);
      wrap_lo   <= carry;
      wrap_hi   <= hi_rolls;
      wrap_pair <= pair_mode & carry & hi_rolls;
    end
  end

  assert_lo_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lo && !(wr_en && !wr_sel)) |=> count_lo == $past(count_lo) + WIDTH'(1));

  assert_lo_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_lo && !(wr_en && !wr_sel)) |=> $stable(count_lo));

  assert_hi_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_mode && run_hi && !(wr_en && wr_sel)) |=> count_hi == $past(count_hi) + WIDTH'(1));

  assert_hi_waits_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode && !(wr_en && wr_sel) &&
     !(run_lo && run_hi && count_lo == ALL_ONES && !(wr_en && !wr_sel))) |=> $stable(count_hi));

  assert_load_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> count_lo == $past(wr_data));

  assert_load_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> count_hi == $past(wr_data));

  assert_wrap_lo_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_lo |-> count_lo == '0);

  assert_wrap_hi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hi |-> count_hi == '0);

  assert_wrap_pair_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pair |-> (wrap_lo && wrap_hi));

endmodule

// File: tb/dual_tick_counter_bench.sv
module dual_tick_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pair_mode = 1'b0, run_lo = 1'b0, run_hi = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] count_lo, count_hi;
  logic       wrap_lo, wrap_hi, wrap_pair;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_tick_counter #(.WIDTH(8)) u_dual_tick_counter (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .run_lo(run_lo), .run_hi(run_hi),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_lo(count_lo), .count_hi(count_hi),
    .wrap_lo(wrap_lo), .wrap_hi(wrap_hi), .wrap_pair(wrap_pair));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input bit sel, input logic [7:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    run_lo = 1'b0; run_hi = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "count_lo", count_lo, 0);
    chk("R1", "count_hi", count_hi, 0);
    chk("R1", "wraps", {wrap_lo, wrap_hi, wrap_pair}, 0);
    tick(3);
    chk("R1", "still stopped", {count_hi, count_lo}, 0);
  endtask

  task automatic t_lo_alone();
    pair_mode = 1'b0; run_lo = 1'b1;
    tick(5);
    chk("R2", "lo after 5", count_lo, 5);
    chk("R3", "hi untouched", count_hi, 0);
    run_lo = 1'b0;
    tick(3);
    chk("R2", "lo holds", count_lo, 5);
  endtask

  task automatic t_hi_alone();
    pair_mode = 1'b0; run_hi = 1'b1;
    tick(4);
    chk("R3", "hi after 4", count_hi, 4);
    chk("R3", "lo untouched", count_lo, 5);
    idle();
    tick(1);
  endtask

  task automatic t_write_priority();
    pair_mode = 1'b0; run_lo = 1'b1; run_hi = 1'b1;
    load(1'b0, 8'h3C);
    chk("R7", "lo loaded over step", count_lo, 8'h3C);
    load(1'b1, 8'hA0);
    chk("R7", "hi loaded over step", count_hi, 8'hA0);
    chk("R7", "lo ran during hi load", count_lo, 8'h3D);
    idle();
    tick(1);
  endtask

  task automatic t_wrap_bytes();
    pair_mode = 1'b0;
    load(1'b0, 8'hFE);
    load(1'b1, 8'hFF);
    run_lo = 1'b1; run_hi = 1'b1;
    tick(1);
    chk("R9", "hi wrapped", count_hi, 0);
    chk("R9", "wrap_hi pulse", wrap_hi, 1);
    chk("R8", "wrap_lo quiet", wrap_lo, 0);
    tick(1);
    chk("R8", "wrap_lo pulse", wrap_lo, 1);
    chk("R8", "lo wrapped", count_lo, 0);
    chk("R9", "wrap_hi one cycle", wrap_hi, 0);
    chk("R10", "no pair wrap in byte mode", wrap_pair, 0);
    chk("R3", "hi independent", count_hi, 1);
    tick(1);
    chk("R8", "wrap_lo one cycle", wrap_lo, 0);
    idle();
  endtask

  task automatic t_cascade();
    pair_mode = 1'b1;
    load(1'b0, 8'hFD);
    load(1'b1, 8'h12);
    run_lo = 1'b1; run_hi = 1'b1;
    tick(2);
    chk("R4", "hi waits for carry", count_hi, 8'h12);
    chk("R4", "lo at top", count_lo, 8'hFF);
    tick(1);
    chk("R4", "hi took carry", count_hi, 8'h13);
    chk("R8", "wrap_lo in pair", wrap_lo, 1);
    chk("R10", "pair not wrapped", wrap_pair, 0);
    idle();
  endtask

  task automatic t_pair_stopped();
    pair_mode = 1'b1;
    load(1'b0, 8'hFF);
    run_lo = 1'b0; run_hi = 1'b1;
    tick(3);
    chk("R5", "pair held", {count_hi, count_lo}, 16'h13FF);
    idle();
  endtask

  task automatic t_hi_gated();
    pair_mode = 1'b1;
    run_lo = 1'b1; run_hi = 1'b0;
    tick(1);
    chk("R6", "lo wrapped", count_lo, 0);
    chk("R6", "hi held", count_hi, 8'h13);
    chk("R6", "wrap_lo", wrap_lo, 1);
    idle();
  endtask

  task automatic t_pair_wrap();
    pair_mode = 1'b1;
    load(1'b0, 8'hFF);
    load(1'b1, 8'hFF);
    run_lo = 1'b1; run_hi = 1'b1;
    tick(1);
    chk("R10", "pair value", {count_hi, count_lo}, 0);
    chk("R10", "pulses", {wrap_lo, wrap_hi, wrap_pair}, 3'b111);
    tick(1);
    chk("R10", "pulse ends", wrap_pair, 0);
    idle();
  endtask

  task automatic t_load_kills_carry();
    pair_mode = 1'b1;
    load(1'b0, 8'hFF);
    load(1'b1, 8'h20);
    run_lo = 1'b1; run_hi = 1'b1;
    load(1'b0, 8'h05);
    chk("R7", "lo loaded", count_lo, 8'h05);
    chk("R7", "no carry", count_hi, 8'h20);
    chk("R7", "no wrap_lo", wrap_lo, 0);
    idle();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_lo_alone();
    t_hi_alone();
    t_write_priority();
    t_wrap_bytes();
    t_cascade();
    t_pair_stopped();
    t_hi_gated();
    t_pair_wrap();
    t_load_kills_carry();
    done = 1'b1;
    report();
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end
endmodule